// File: doc/BRIEF.md
# Colour LCD Controller Register Bank

This block is the bus-facing register bank of a colour LCD controller. A host reaches it through a plain 32-bit read/write port addressed by byte offset, with word granularity. It stores four panel timing words, the frame base addresses of the upper and lower panels, a control word and an interrupt mask. It tracks raw interrupt events and serves a read-only identification window. From the stored words it derives the values the display pipeline consumes: panel width and height, the pixel depth code, the colour-order and byte-order flags, and a display-enable flag.

Palette storage sits outside the block. Accesses that fall in the palette address window are forwarded through a small side port: a write strobe, an entry index and a read return path. A strap input chooses a board variant that exchanges the offsets of the control word and the interrupt mask. Every accepted write raises a one-cycle redraw request toward the display path.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every stored register is zero: reads return 0, pixel depth code is 0, display enable and the interrupt output are low, width reads 16 and height reads 1.
- R2: Word offsets 0 to 3 (timing words), 4 (upper base) and 5 (lower base) read back the full 32-bit value last written; word offsets 11 and 12 read the upper and lower base and ignore writes.
- R3: Panel width in pixels equals ((timing0 AND 0xFC) + 4) * 4, so it follows timing0 bits [7:2] and spans 16 to 1024.
- R4: Panel height in lines equals (timing1 bits [9:0]) + 1, spanning 1 to 1024.
- R5: The control word keeps its low 16 bits (upper bits read 0). Depth code = bits [3:1] (0..5 meaning 1, 2, 4, 8, 16, 32 bpp), colour-order flag = bit 8, byte-order flag = bit 9, pixel-order flag = bit 10, and display enable = bit 0 AND bit 11.
- R6: With the strap low, word offset 6 is the interrupt mask and 7 is the control word; with the strap high the two offsets are exchanged for both reads and writes.
- R7: A high cycle on an event input bit sets the matching raw status bit, which stays set; word offset 8 reads raw status, word offset 9 reads raw AND mask, and the interrupt output is high when any masked bit is set.
- R8: A write to word offset 10 clears each raw status bit whose write-data bit is 1; an event on the same bit in the same cycle wins and leaves it set; offset 10 reads 0.
- R9: Word offsets 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) return, in bits [7:0], the identification bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rising offset order; writes there are ignored.
- R10: Byte offsets 0x200 to 0x3FC form the palette window: a write raises the palette write strobe in the same cycle with entry index (offset - 0x200) / 4 and write data taken from the bus, and a read returns the palette read data input.
- R11: The redraw request is high for exactly the one cycle after a write to a writable offset (0 to 7, 10, or the palette window), and stays low after writes to any other offset.
- R12: Any other offset reads 0 and a write there changes no register.
- R13: Read data is registered: it shows the addressed value in the cycle after the read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_i | input | 1 | Board variant strap, exchanges mask and control offsets |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset, bits [1:0] ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_event | input | 5 | One-cycle interrupt event pulses, one per status bit |
| irq_o | output | 1 | OR of the masked status bits |
| invalidate_o | output | 1 | One-cycle full-frame redraw request |
| pal_wr_o | output | 1 | Palette write strobe |
| pal_idx_o | output | 7 | Palette entry index |
| pal_rdata_i | input | 32 | Palette read data |
| pan_width_o | output | 11 | Panel width in pixels |
| pan_height_o | output | 11 | Panel height in lines |
| bpp_mode_o | output | 3 | Pixel depth code |
| bgr_o | output | 1 | Colour-order flag |
| be_byte_o | output | 1 | Byte-order flag |
| be_pix_o | output | 1 | Pixel-order flag |
| disp_en_o | output | 1 | Display enable |
| up_base_o | output | 32 | Upper panel frame base |
| lo_base_o | output | 32 | Lower panel frame base |

## Verification
The bench aims at the width formula at both ends of its range and with the low two timing bits set, where a design that failed to mask bits [1:0] would report a width off by a few pixels. It flips the variant strap and checks both offsets in both directions, which catches a decoder that swaps only writes or only reads. It fires an event and a clear on the same bit in one cycle, where a clear-priority design would drop the interrupt. It writes to the identification window, read-only offsets and an unmapped offset, where a loose decoder would corrupt a register or raise a spurious redraw request.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

   localparam int unsigned WOFF_MASK  = 6;
   localparam int unsigned WOFF_CTRL  = 7;
   localparam int unsigned WOFF_RAW   = 8;
   localparam int unsigned WOFF_MIS   = 9;
   localparam int unsigned WOFF_CLR   = 10;
   localparam int unsigned WOFF_UPCUR = 11;
   localparam int unsigned WOFF_LOCUR = 12;
   localparam int unsigned N_TIMING   = 4;

   typedef struct packed {
      logic [N_TIMING-1:0] tim;
      logic upb;
      logic lob;
      logic msk;
      logic ctl;
      logic raw;
      logic mis;
      logic clr;
      logic upc;
      logic loc;
      logic idw;
      logic pal;
   } lcdc_sel_t;

   function automatic logic [7:0] lcdc_id_byte(input logic [2:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0: b = 8'h10;
         3'd1: b = 8'h11;
         3'd2: b = 8'h04;
         3'd3: b = 8'h00;
         3'd4: b = 8'h0D;
         3'd5: b = 8'hF0;
         3'd6: b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
   import lcdc_pkg::*;
#(
   parameter int unsigned WA_W = 10
) (
   input  logic [WA_W-1:0] word,
   input  logic            variant,
   output lcdc_sel_t       sel
);
   localparam int unsigned PAL_HI = WA_W - 3;

   if (WA_W != 10) begin : g_bad_width
      $error("lcdc_addr_dec: word address must be 10 bits");
   end

   logic low_page;
   assign low_page = (word[WA_W-1:4] == '0);

   always_comb begin
      sel = '0;
      if (low_page) begin
         for (int i = 0; i < N_TIMING; i++)
            sel.tim[i] = (word[3:0] == 4'(i));
         sel.upb = (word[3:0] == 4'd4);
         sel.lob = (word[3:0] == 4'd5);
         if (variant) begin
            sel.ctl = (word[3:0] == 4'(WOFF_MASK));
            sel.msk = (word[3:0] == 4'(WOFF_CTRL));
         end else begin
            sel.msk = (word[3:0] == 4'(WOFF_MASK));
            sel.ctl = (word[3:0] == 4'(WOFF_CTRL));
         end
         sel.raw = (word[3:0] == 4'(WOFF_RAW));
         sel.mis = (word[3:0] == 4'(WOFF_MIS));
         sel.clr = (word[3:0] == 4'(WOFF_CLR));
         sel.upc = (word[3:0] == 4'(WOFF_UPCUR));
         sel.loc = (word[3:0] == 4'(WOFF_LOCUR));
      end
      sel.idw = (word[WA_W-1:3] == '1);
      sel.pal = (word[WA_W-1:PAL_HI] == 3'b001);
   end

endmodule

// File: rtl/lcdc_irq_bank.sv
module lcdc_irq_bank #(
   parameter int unsigned IRQ_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] ev,
   input  logic             mask_we,
   input  logic             clr_we,
   input  logic [IRQ_W-1:0] wbits,
   output logic [IRQ_W-1:0] raw,
   output logic [IRQ_W-1:0] mask,
   output logic             irq
);
   if (IRQ_W < 1 || IRQ_W > 32) begin : g_bad_irq
      $error("lcdc_irq_bank: IRQ_W must be 1..32");
   end

   for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            raw[b]  <= 1'b0;
            mask[b] <= 1'b0;
         end else begin
            if (ev[b])
               raw[b] <= 1'b1;
            else if (clr_we && wbits[b])
               raw[b] <= 1'b0;
            if (mask_we)
               mask[b] <= wbits[b];
         end
      end
   end

   assign irq = |(raw & mask);

endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
   parameter int unsigned DIM_W = 11
) (
   input  logic [5:0]       t0_ppl,
   input  logic [9:0]       t1_lpp,
   input  logic [2:0]       ctl_bpp,
   input  logic [3:0]       ctl_hi,
   input  logic             ctl_en,
   output logic [DIM_W-1:0] width,
   output logic [DIM_W-1:0] height,
   output logic [2:0]       bpp,
   output logic             bgr,
   output logic             be_byte,
   output logic             be_pix,
   output logic             enable
);
   if (DIM_W < 11) begin : g_bad_dim
      $error("lcdc_geom: DIM_W must hold 1024");
   end

   logic [DIM_W-1:0] ppl_plus;
   assign ppl_plus = DIM_W'(t0_ppl) + DIM_W'(1);
   assign width    = ppl_plus << 4;
   assign height   = DIM_W'(t1_lpp) + DIM_W'(1);
   assign bpp      = ctl_bpp;
   assign bgr      = ctl_hi[0];
   assign be_byte  = ctl_hi[1];
   assign be_pix   = ctl_hi[2];
   assign enable   = ctl_en & ctl_hi[3];

endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
   import lcdc_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IRQ_W  = 5,
   parameter int unsigned CTRL_W = 16,
   parameter int unsigned DIM_W  = 11,
   parameter int unsigned PIDX_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              variant_i,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [IRQ_W-1:0]  irq_event,
   output logic              irq_o,
   output logic              invalidate_o,
   output logic              pal_wr_o,
   output logic [PIDX_W-1:0] pal_idx_o,
   input  logic [DATA_W-1:0] pal_rdata_i,
   output logic [DIM_W-1:0]  pan_width_o,
   output logic [DIM_W-1:0]  pan_height_o,
   output logic [2:0]        bpp_mode_o,
   output logic              bgr_o,
   output logic              be_byte_o,
   output logic              be_pix_o,
   output logic              disp_en_o,
   output logic [DATA_W-1:0] up_base_o,
   output logic [DATA_W-1:0] lo_base_o
);
   localparam int unsigned WA_W = ADDR_W - 2;

   if (ADDR_W != 12) begin : g_bad_addr
      $error("lcdc_regbank: ADDR_W must be 12");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("lcdc_regbank: DATA_W must be 32");
   end
   if (CTRL_W < 12 || CTRL_W > DATA_W) begin : g_bad_ctrl
      $error("lcdc_regbank: CTRL_W out of range");
   end
   if (PIDX_W != WA_W - 3) begin : g_bad_pidx
      $error("lcdc_regbank: PIDX_W must match the palette window");
   end

   logic [WA_W-1:0]   word;
   logic [1:0]        unused_byte_lane;
   lcdc_sel_t         sel;
   logic [DATA_W-1:0] timing_q [N_TIMING];
   logic [DATA_W-1:0] up_q, lo_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [IRQ_W-1:0]  irq_raw, irq_mask;
   logic              wr_hit;
   logic              inv_q;
   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] rdata_q;

   assign word             = addr[ADDR_W-1:2];
   assign unused_byte_lane = addr[1:0];

   lcdc_addr_dec #(.WA_W(WA_W)) u_dec (
      .word    (word),
      .variant (variant_i),
      .sel     (sel)
   );

   for (genvar t = 0; t < N_TIMING; t++) begin : g_tim
      always_ff @(posedge clk) begin
         if (!rst_n)
            timing_q[t] <= '0;
         else if (wr_en && sel.tim[t])
            timing_q[t] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q   <= '0;
         lo_q   <= '0;
         ctrl_q <= '0;
      end else if (wr_en) begin
         if (sel.upb) up_q   <= wdata;
         if (sel.lob) lo_q   <= wdata;
         if (sel.ctl) ctrl_q <= wdata[CTRL_W-1:0];
      end
   end

   lcdc_irq_bank #(.IRQ_W(IRQ_W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (irq_event),
      .mask_we (wr_en && sel.msk),
      .clr_we  (wr_en && sel.clr),
      .wbits   (wdata[IRQ_W-1:0]),
      .raw     (irq_raw),
      .mask    (irq_mask),
      .irq     (irq_o)
   );

   lcdc_geom #(.DIM_W(DIM_W)) u_geom (
      .t0_ppl  (timing_q[0][7:2]),
      .t1_lpp  (timing_q[1][9:0]),
      .ctl_bpp (ctrl_q[3:1]),
      .ctl_hi  (ctrl_q[11:8]),
      .ctl_en  (ctrl_q[0]),
      .width   (pan_width_o),
      .height  (pan_height_o),
      .bpp     (bpp_mode_o),
      .bgr     (bgr_o),
      .be_byte (be_byte_o),
      .be_pix  (be_pix_o),
      .enable  (disp_en_o)
   );

   assign wr_hit = wr_en && ((|sel.tim) || sel.upb || sel.lob || sel.msk ||
                             sel.ctl || sel.clr || sel.pal);

   always_ff @(posedge clk) begin
      if (!rst_n) inv_q <= 1'b0;
      else        inv_q <= wr_hit;
   end
   assign invalidate_o = inv_q;

   assign pal_wr_o  = wr_en && sel.pal;
   assign pal_idx_o = word[PIDX_W-1:0];

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N_TIMING; i++)
         if (sel.tim[i]) rd_val = timing_q[i];
      if (sel.upb || sel.upc) rd_val = up_q;
      if (sel.lob || sel.loc) rd_val = lo_q;
      if (sel.ctl)            rd_val = DATA_W'(ctrl_q);
      if (sel.msk)            rd_val = DATA_W'(irq_mask);
      if (sel.raw)            rd_val = DATA_W'(irq_raw);
      if (sel.mis)            rd_val = DATA_W'(irq_raw & irq_mask);
      if (sel.idw)            rd_val = DATA_W'(lcdc_id_byte(word[2:0]));
      if (sel.pal)            rd_val = pal_rdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_val;
   end
   assign rdata = rdata_q;

   assign up_base_o = up_q;
   assign lo_base_o = lo_q;

endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk #(
   parameter int unsigned IRQ_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [11:0]      addr,
   input logic [31:0]      wdata,
   input logic [31:0]      rdata,
   input logic [IRQ_W-1:0] irq_event,
   input logic [IRQ_W-1:0] raw,
   input logic [IRQ_W-1:0] mask,
   input logic             irq_o,
   input logic             invalidate_o,
   input logic [10:0]      pan_width_o,
   input logic [10:0]      pan_height_o,
   input logic             disp_en_o
);
   // R11: a redraw request only follows a write
   p_inv_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      invalidate_o |-> $past(wr_en));

   // R13: read data holds when no read is issued
   p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R8: clear write with no event leaves the written bits clear
   p_clear_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[11:2] == 10'd10 && irq_event == '0)
      |=> ((raw & $past(wdata[IRQ_W-1:0])) == '0));

   // R7: an event on an unmasked bit raises the interrupt next cycle
   p_event_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (|(irq_event & mask))) |=> irq_o);

   // R5: panel configuration changes only through writes
   p_cfg_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(disp_en_o) && $stable(pan_width_o) && $stable(pan_height_o)));

   // R3: width is a multiple of 16 within range
   p_width_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pan_width_o[3:0] == 4'd0) && (pan_width_o >= 11'd16) && (pan_width_o <= 11'd1024));

   // R4: height stays within range
   p_height_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pan_height_o >= 11'd1) && (pan_height_o <= 11'd1024));
endmodule

bind lcdc_regbank lcdc_regbank_chk #(.IRQ_W(IRQ_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .addr         (addr),
   .wdata        (wdata),
   .rdata        (rdata),
   .irq_event    (irq_event),
   .raw          (irq_raw),
   .mask         (irq_mask),
   .irq_o        (irq_o),
   .invalidate_o (invalidate_o),
   .pan_width_o  (pan_width_o),
   .pan_height_o (pan_height_o),
   .disp_en_o    (disp_en_o)
);

// File: tb/lcdc_regbank_test.sv
`timescale 1ns/1ps
module lcdc_regbank_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        variant_i = 0;
   logic        wr_en = 0, rd_en = 0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [4:0]  irq_event = '0;
   logic        irq_o, invalidate_o, pal_wr_o;
   logic [6:0]  pal_idx_o;
   logic [31:0] pal_rdata_i;
   logic [10:0] pan_width_o, pan_height_o;
   logic [2:0]  bpp_mode_o;
   logic        bgr_o, be_byte_o, be_pix_o, disp_en_o;
   logic [31:0] up_base_o, lo_base_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic last_inv;
   logic [31:0] rv;

   always #5 clk = ~clk;

   assign pal_rdata_i = {25'h0ABCDEF, pal_idx_o};

   lcdc_regbank uut (
      .clk(clk), .rst_n(rst_n), .variant_i(variant_i), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_event(irq_event), .irq_o(irq_o),
      .invalidate_o(invalidate_o), .pal_wr_o(pal_wr_o), .pal_idx_o(pal_idx_o),
      .pal_rdata_i(pal_rdata_i), .pan_width_o(pan_width_o), .pan_height_o(pan_height_o),
      .bpp_mode_o(bpp_mode_o), .bgr_o(bgr_o), .be_byte_o(be_byte_o), .be_pix_o(be_pix_o),
      .disp_en_o(disp_en_o), .up_base_o(up_base_o), .lo_base_o(lo_base_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(posedge clk); #1;
      last_inv = invalidate_o;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1; addr = a;
      @(posedge clk); #1;
      d = rdata;
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic t_reset;
      bus_read(12'h000, rv); chk("R1 timing0", rv, 0);
      bus_read(12'h01C, rv); chk("R1 control", rv, 0);
      chk("R1 width",  32'(pan_width_o), 16);
      chk("R1 height", 32'(pan_height_o), 1);
      chk("R1 bpp",    32'(bpp_mode_o), 0);
      chk("R1 en/irq/inv", {29'h0, disp_en_o, irq_o, invalidate_o}, 0);
   endtask

   task automatic t_timing;
      bus_write(12'h000, 32'h0000_00FC);
      chk("R3 width max", 32'(pan_width_o), 1024);
      chk("R11 inv after write", 32'(last_inv), 1);
      @(posedge clk); #1;
      chk("R11 inv one cycle", 32'(invalidate_o), 0);
      bus_write(12'h000, 32'hFFFF_FF13);
      chk("R3 width low bits masked", 32'(pan_width_o), 80);
      bus_read(12'h000, rv); chk("R2 timing0 readback", rv, 32'hFFFF_FF13);
      bus_write(12'h004, 32'h0000_03FF);
      chk("R4 height max", 32'(pan_height_o), 1024);
      bus_write(12'h004, 32'hFFFF_F800);
      chk("R4 height min", 32'(pan_height_o), 1);
      bus_read(12'h004, rv); chk("R2 timing1 readback", rv, 32'hFFFF_F800);
      bus_write(12'h008, 32'h1234_5678);
      bus_write(12'h00C, 32'h9ABC_DEF0);
      bus_write(12'h010, 32'h8000_1000);
      bus_write(12'h014, 32'h0040_0000);
      bus_read(12'h008, rv); chk("R2 timing2", rv, 32'h1234_5678);
      bus_read(12'h00C, rv); chk("R2 timing3", rv, 32'h9ABC_DEF0);
      bus_read(12'h02C, rv); chk("R2 upper current", rv, 32'h8000_1000);
      bus_read(12'h030, rv); chk("R2 lower current", rv, 32'h0040_0000);
      chk("R2 base ports", up_base_o ^ lo_base_o, 32'h8040_1000);
      bus_write(12'h02C, 32'h0);
      chk("R2 current write ignored", up_base_o, 32'h8000_1000);
      chk("R11 no inv on read-only", 32'(last_inv), 0);
   endtask

   task automatic t_ctrl;
      bus_write(12'h01C, 32'h0000_0801);
      chk("R5 enable both", 32'(disp_en_o), 1);
      bus_write(12'h01C, 32'h0000_0001);
      chk("R5 enable no power", 32'(disp_en_o), 0);
      bus_write(12'h01C, 32'hFFFF_0F0A);
      chk("R5 bpp", 32'(bpp_mode_o), 5);
      chk("R5 flags", {28'h0, bgr_o, be_byte_o, be_pix_o, disp_en_o}, 32'hE);
      bus_read(12'h01C, rv); chk("R5 ctrl upper zero", rv, 32'h0000_0F0A);
   endtask

   task automatic t_variant;
      bus_write(12'h01C, 32'h0);
      bus_write(12'h018, 32'h0000_0003);
      bus_read(12'h018, rv); chk("R6 mask at 6 strap low", rv, 3);
      @(negedge clk); variant_i = 1;
      bus_write(12'h018, 32'h0000_0801);
      chk("R6 strap high ctrl at 6", 32'(disp_en_o), 1);
      bus_read(12'h01C, rv); chk("R6 strap high mask at 7", rv, 3);
      bus_write(12'h01C, 32'h0000_0001);
      bus_read(12'h018, rv); chk("R6 strap high ctrl read", rv, 32'h801);
      @(negedge clk); variant_i = 0;
      bus_read(12'h018, rv); chk("R6 strap low mask back", rv, 1);
      bus_read(12'h01C, rv); chk("R6 strap low ctrl back", rv, 32'h801);
      bus_write(12'h018, 32'h0);
   endtask

   task automatic t_irq;
      @(negedge clk); irq_event = 5'b00100;
      @(negedge clk); irq_event = '0;
      bus_read(12'h020, rv); chk("R7 raw set", rv, 4);
      bus_read(12'h024, rv); chk("R7 masked zero", rv, 0);
      chk("R7 irq low masked", 32'(irq_o), 0);
      bus_write(12'h018, 32'h4);
      chk("R7 irq high", 32'(irq_o), 1);
      bus_read(12'h024, rv); chk("R7 masked", rv, 4);
      bus_write(12'h028, 32'h1);
      bus_read(12'h020, rv); chk("R8 other bit kept", rv, 4);
      bus_write(12'h028, 32'h4);
      bus_read(12'h020, rv); chk("R8 cleared", rv, 0);
      chk("R8 irq dropped", 32'(irq_o), 0);
      @(negedge clk);
      irq_event = 5'b00010; wr_en = 1; addr = 12'h028; wdata = 32'h2;
      @(negedge clk);
      irq_event = '0; wr_en = 0;
      bus_read(12'h020, rv); chk("R8 event wins", rv, 2);
      bus_read(12'h028, rv); chk("R8 clear reads zero", rv, 0);
   endtask

   task automatic t_id;
      logic [7:0] idb [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++) begin
         bus_read(12'hFE0 + 12'(4 * i), rv);
         chk("R9 id byte", rv, 32'(idb[i]));
      end
      bus_write(12'hFE0, 32'hFFFF_FFFF);
      chk("R11 no inv on id", 32'(last_inv), 0);
      bus_read(12'hFE0, rv); chk("R9 id write ignored", rv, 32'h10);
   endtask

   task automatic t_pal;
      @(negedge clk);
      wr_en = 1; addr = 12'h204; wdata = 32'h55;
      #1;
      chk("R10 pal strobe", {24'h0, pal_wr_o, pal_idx_o}, {24'h0, 1'b1, 7'd1});
      @(posedge clk); #1;
      chk("R11 inv on palette", 32'(invalidate_o), 1);
      @(negedge clk); wr_en = 0;
      #1; chk("R10 strobe low", 32'(pal_wr_o), 0);
      bus_read(12'h3FC, rv); chk("R10 pal read", rv, {25'h0ABCDEF, 7'd127});
   endtask

   task automatic t_unmapped;
      bus_read(12'h000, rv);
      bus_write(12'h034, 32'hFFFF_FFFF);
      chk("R12 no inv unmapped", 32'(last_inv), 0);
      bus_read(12'h034, rv); chk("R12 reads zero", rv, 0);
      bus_read(12'h000, rv); chk("R12 timing0 unchanged", rv, 32'hFFFF_FF13);
      bus_write(12'h100, 32'hFFFF_FFFF);
      bus_read(12'h01C, rv); chk("R12 ctrl unchanged", rv, 32'h801);
      bus_write(12'h020, 32'h1F);
      bus_read(12'h020, rv); chk("R12 raw write ignored", rv, 2);
   endtask

   task automatic t_hold;
      bus_read(12'h010, rv);
      repeat (3) @(posedge clk);
      #1; chk("R13 rdata held", rdata, 32'h8000_1000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      t_reset;
      t_timing;
      t_ctrl;
      t_variant;
      t_irq;
      t_id;
      t_pal;
      t_unmapped;
      t_hold;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule